// File: doc/BRIEF.md
# Output Driver Power-Up Sequencer

This block brings an external four-channel low-side output driver from power-up to a configured, enabled state. After its own reset it holds the driver's reset pin low for a fixed time, waits a settle period, then issues a fixed series of register frames through a separate frame engine. That engine handles serialisation and parity. The sequencer reads back the identity and power-on-reset status, writes three configuration registers built from static input ports, and finally writes the global status register to turn the outputs on.

The driver answers each frame with the contents addressed by the previous frame. So the first identity check arrives as the reply to a status read. The block ends in one of two terminal states. In the done state, communication-fault reporting is enabled. In the error state, a code identifies the failing step and whether the link or the reply content was at fault. Any later runtime control is left to other logic.

Top module: `drv_init_seq`

## Requirements
- R1: After `rst_n` rises, `drv_reset_n` stays low for exactly HOLD = CLK_KHZ*RST_HOLD_US/1000 rising edges and is high from then on. `drv_en` is high (when HAS_EN=1) from reset onward, so it is active before the reset pin is released. `drv_ctrl` is all zeros at all times.
- R2: The first frame request is issued in the cycle after the SETTLE-th rising edge following the release of `drv_reset_n`, where SETTLE = CLK_KHZ*SETTLE_US/1000. It is a read (`frm_wr`=0) of address 0x7 with data 0x00. No request is issued while `drv_reset_n` is low.
- R3: The reply to the first frame must carry address 0x8 and data 0xB1. Otherwise the sequence stops in error with `err_code` = 4'h9.
- R4: The second frame is a read of address 0x7 with data 0x00. Its reply must carry address 0x7 with data bit 0 set. Otherwise the sequence stops in error with `err_code` = 4'hA.
- R5: The third frame writes address 0x1 with data {2'b00, cfg_par34, cfg_par12, cfg_direct[3:0]}. The top two bits at zero switch the driver's communication watchdog off.
- R6: The fourth frame writes address 0x2 with data {2'b00, cfg_diag_filt[1:0], 4'hF}.
- R7: The fifth frame writes address 0x3 with data {3'b000, cfg_oc_filt[2:0], cfg_oc_thr[1:0]}.
- R8: The sixth frame writes address 0x7 with data 0x80. On its clean reply, `done` and `comm_fault_en` go high after the same edge that samples `frm_ack`. `comm_fault_en` is low at all other times before that.
- R9: A reply with `frm_par_err` or `frm_xfer_err` set stops the sequence at once. `error` goes high and `err_code` = {1'b0, step}, where step 1..6 is the frame number. No further frame is issued.
- R10: Only one frame is outstanding at a time. `frm_req` is a one-cycle pulse, and each later request appears in the cycle after the edge that samples a clean `frm_ack`. The frame fields stay stable until that ack.
- R11: `done`, `error` and `err_code` stay constant once set, until the next `rst_n`. `done` and `error` are never high together.
- R12: When a reply carries a link fault and also fails its content check, the link fault wins. `err_code` then has bit 3 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts a new sequence on release |
| cfg_par12 | input | 1 | Pair outputs 1 and 2 in parallel |
| cfg_par34 | input | 1 | Pair outputs 3 and 4 in parallel |
| cfg_direct | input | 4 | Bit i marks output i+1 as driven by its direct pin |
| cfg_diag_filt | input | 2 | Off-state diagnostic filter code |
| cfg_oc_filt | input | 3 | Overcurrent filter time code |
| cfg_oc_thr | input | 2 | Overcurrent threshold code |
| frm_req | output | 1 | One-cycle frame request to the frame engine |
| frm_wr | output | 1 | Frame is a write |
| frm_addr | output | 4 | Frame register address |
| frm_wdata | output | 8 | Frame payload |
| frm_ack | input | 1 | Reply valid for one cycle |
| frm_raddr | input | 4 | Address field of the reply |
| frm_rdata | input | 8 | Data field of the reply |
| frm_par_err | input | 1 | Reply failed its parity check |
| frm_xfer_err | input | 1 | Transfer failed |
| drv_reset_n | output | 1 | Driver reset pin, active low |
| drv_en | output | 1 | Driver enable pin |
| drv_ctrl | output | 4 | Direct control pins, held inactive |
| comm_fault_en | output | 1 | Communication-fault reporting enabled |
| done | output | 1 | Sequence completed |
| error | output | 1 | Sequence aborted |
| err_code | output | 4 | Bit 3: content fault; bits 2:0: failing step |

## Verification
Two checks can fall in the same cycle. A single reply can carry a link fault (parity or transfer) and also carry wrong content: a bad address or identity value on the first step. The bench provokes this by answering the identity read with `frm_par_err` set and a wrong identity value. It then expects `err_code` 4'h1, not 4'h9, and expects no later request. A reference model in the bench predicts the request, pin and status outputs on every cycle.

// File: rtl/drv_init_pkg.sv
package drv_init_pkg;

    localparam int NUM_OUT = 4;

    localparam logic [3:0] ADDR_CFG    = 4'h1;
    localparam logic [3:0] ADDR_OFFD   = 4'h2;
    localparam logic [3:0] ADDR_OND    = 4'h3;
    localparam logic [3:0] ADDR_GSTAT  = 4'h7;
    localparam logic [3:0] ADDR_IDENT  = 4'h8;
    localparam logic [7:0] IDENT_VALUE = 8'hB1;
    localparam int         POR_BIT     = 0;
    localparam int         OUTEN_BIT   = 7;

    typedef enum logic [3:0] {
        ST_HOLD   = 4'd0,
        ST_SETTLE = 4'd1,
        ST_ID     = 4'd2,
        ST_POR    = 4'd3,
        ST_CFG    = 4'd4,
        ST_OFFD   = 4'd5,
        ST_OND    = 4'd6,
        ST_GLOB   = 4'd7,
        ST_DONE   = 4'd8,
        ST_FAIL   = 4'd9
    } state_e;

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [7:0] data;
    } frame_t;

    function automatic logic is_frame_step(state_e s);
        return (s >= ST_ID) && (s <= ST_GLOB);
    endfunction

    function automatic logic [2:0] step_num(state_e s);
        return 3'(s - ST_ID + 1);
    endfunction

endpackage

// File: rtl/drv_init_timer.sv
module drv_init_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    assign last = run && (cnt_q == limit - W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (run) begin
            cnt_d = last ? '0 : cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/drv_init_compose.sv
module drv_init_compose
    import drv_init_pkg::*;
(
    input  state_e       step,
    input  logic         cfg_par12,
    input  logic         cfg_par34,
    input  logic [NUM_OUT-1:0] cfg_direct,
    input  logic [1:0]   cfg_diag_filt,
    input  logic [2:0]   cfg_oc_filt,
    input  logic [1:0]   cfg_oc_thr,
    output frame_t       frame
);
    always_comb begin
        frame = '0;
        unique case (step)
            ST_ID, ST_POR: begin
                frame.wr   = 1'b0;
                frame.addr = ADDR_GSTAT;
            end
            ST_CFG: begin
                frame.wr   = 1'b1;
                frame.addr = ADDR_CFG;
                frame.data = {2'b00, cfg_par34, cfg_par12, cfg_direct};
            end
            ST_OFFD: begin
                frame.wr   = 1'b1;
                frame.addr = ADDR_OFFD;
                frame.data = {2'b00, cfg_diag_filt, {NUM_OUT{1'b1}}};
            end
            ST_OND: begin
                frame.wr   = 1'b1;
                frame.addr = ADDR_OND;
                frame.data = {3'b000, cfg_oc_filt, cfg_oc_thr};
            end
            ST_GLOB: begin
                frame.wr   = 1'b1;
                frame.addr = ADDR_GSTAT;
                frame.data = 8'(1) << OUTEN_BIT;
            end
            default: frame = '0;
        endcase
    end
endmodule

// File: rtl/drv_init_judge.sv
module drv_init_judge
    import drv_init_pkg::*;
(
    input  state_e     step,
    input  logic [3:0] raddr,
    input  logic [7:0] rdata,
    input  logic       par_err,
    input  logic       xfer_err,
    output logic       link_bad,
    output logic       content_bad
);
    always_comb begin
        link_bad    = par_err || xfer_err;
        content_bad = 1'b0;
        unique case (step)
            ST_ID:  content_bad = (raddr != ADDR_IDENT) || (rdata != IDENT_VALUE);
            ST_POR: content_bad = (raddr != ADDR_GSTAT) || !rdata[POR_BIT];
            default: content_bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/drv_init_seq.sv
module drv_init_seq
    import drv_init_pkg::*;
#(
    parameter int CLK_KHZ     = 250000,
    parameter int RST_HOLD_US = 10,
    parameter int SETTLE_US   = 210,
    parameter bit HAS_EN      = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_par12,
    input  logic       cfg_par34,
    input  logic [3:0] cfg_direct,
    input  logic [1:0] cfg_diag_filt,
    input  logic [2:0] cfg_oc_filt,
    input  logic [1:0] cfg_oc_thr,
    output logic       frm_req,
    output logic       frm_wr,
    output logic [3:0] frm_addr,
    output logic [7:0] frm_wdata,
    input  logic       frm_ack,
    input  logic [3:0] frm_raddr,
    input  logic [7:0] frm_rdata,
    input  logic       frm_par_err,
    input  logic       frm_xfer_err,
    output logic       drv_reset_n,
    output logic       drv_en,
    output logic [3:0] drv_ctrl,
    output logic       comm_fault_en,
    output logic       done,
    output logic       error,
    output logic [3:0] err_code
);
    localparam int HOLD_CYC   = (CLK_KHZ * RST_HOLD_US) / 1000 > 0 ? (CLK_KHZ * RST_HOLD_US) / 1000 : 1;
    localparam int SETTLE_CYC = (CLK_KHZ * SETTLE_US) / 1000 > 0 ? (CLK_KHZ * SETTLE_US) / 1000 : 1;
    localparam int MAX_CYC    = HOLD_CYC > SETTLE_CYC ? HOLD_CYC : SETTLE_CYC;
    localparam int CW         = $clog2(MAX_CYC + 1);

    typedef struct packed {
        state_e     st;
        logic       req;
        logic       rstn;
        logic [3:0] code;
    } seq_t;

    seq_t   d, q;
    frame_t cur_frame;
    logic   t_run, t_last, link_bad, content_bad;
    logic [CW-1:0] t_limit;

    assign t_run   = (q.st == ST_HOLD) || (q.st == ST_SETTLE);
    assign t_limit = (q.st == ST_HOLD) ? CW'(HOLD_CYC) : CW'(SETTLE_CYC);

    drv_init_timer #(.W(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (t_run),
        .limit (t_limit),
        .last  (t_last)
    );

    drv_init_compose u_compose (
        .step          (q.st),
        .cfg_par12     (cfg_par12),
        .cfg_par34     (cfg_par34),
        .cfg_direct    (cfg_direct),
        .cfg_diag_filt (cfg_diag_filt),
        .cfg_oc_filt   (cfg_oc_filt),
        .cfg_oc_thr    (cfg_oc_thr),
        .frame         (cur_frame)
    );

    drv_init_judge u_judge (
        .step        (q.st),
        .raddr       (frm_raddr),
        .rdata       (frm_rdata),
        .par_err     (frm_par_err),
        .xfer_err    (frm_xfer_err),
        .link_bad    (link_bad),
        .content_bad (content_bad)
    );

    always_comb begin
        d     = q;
        d.req = 1'b0;
        unique case (q.st)
            ST_HOLD: begin
                if (t_last) begin
                    d.st   = ST_SETTLE;
                    d.rstn = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (t_last) begin
                    d.st  = ST_ID;
                    d.req = 1'b1;
                end
            end
            ST_ID, ST_POR, ST_CFG, ST_OFFD, ST_OND, ST_GLOB: begin
                if (frm_ack && !q.req) begin
                    if (link_bad) begin
                        d.st   = ST_FAIL;
                        d.code = {1'b0, step_num(q.st)};
                    end else if (content_bad) begin
                        d.st   = ST_FAIL;
                        d.code = {1'b1, step_num(q.st)};
                    end else if (q.st == ST_GLOB) begin
                        d.st = ST_DONE;
                    end else begin
                        d.st  = state_e'(q.st + 4'd1);
                        d.req = 1'b1;
                    end
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_HOLD;
            q.req  <= 1'b0;
            q.rstn <= 1'b0;
            q.code <= '0;
        end else begin
            q <= d;
        end
    end

    assign frm_req       = q.req;
    assign frm_wr        = cur_frame.wr;
    assign frm_addr      = cur_frame.addr;
    assign frm_wdata     = cur_frame.data;
    assign drv_reset_n   = q.rstn;
    assign drv_ctrl      = '0;
    assign done          = (q.st == ST_DONE);
    assign comm_fault_en = (q.st == ST_DONE);
    assign error         = (q.st == ST_FAIL);
    assign err_code      = q.code;

    generate
        if (HAS_EN) begin : g_en
            assign drv_en = 1'b1;
            p_en_before_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(drv_reset_n) |-> drv_en);
        end else begin : g_no_en
            assign drv_en = 1'b0;
        end
    endgenerate

    p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frm_req |=> !frm_req);

    p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_req || (is_frame_step(q.st) && !frm_ack)) |=> ($stable(frm_addr) && $stable(frm_wdata)) || done || error);

    p_no_req_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_reset_n |-> !frm_req);

    p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_error_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error && $stable(err_code));

    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    p_code_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (err_code[2:0] != 3'd0));

    p_no_req_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !frm_req);

    p_fault_en_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_reset_n |-> !comm_fault_en);
endmodule

// File: tb/drv_init_seq_test.sv
`timescale 1ns/1ps
module drv_init_seq_test;
    localparam int KHZ    = 1000;
    localparam int HOLD   = 10;
    localparam int SETTLE = 210;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cfg_par12 = 0, cfg_par34 = 0;
    logic [3:0] cfg_direct = 0;
    logic [1:0] cfg_diag_filt = 0;
    logic [2:0] cfg_oc_filt = 0;
    logic [1:0] cfg_oc_thr = 0;
    logic       frm_req, frm_wr;
    logic [3:0] frm_addr;
    logic [7:0] frm_wdata;
    logic       frm_ack = 0;
    logic [3:0] frm_raddr = 0;
    logic [7:0] frm_rdata = 0;
    logic       frm_par_err = 0, frm_xfer_err = 0;
    logic       drv_reset_n, drv_en, comm_fault_en, done, error;
    logic [3:0] drv_ctrl, err_code;

    drv_init_seq #(.CLK_KHZ(KHZ), .RST_HOLD_US(10), .SETTLE_US(210), .HAS_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_par12(cfg_par12), .cfg_par34(cfg_par34), .cfg_direct(cfg_direct),
        .cfg_diag_filt(cfg_diag_filt), .cfg_oc_filt(cfg_oc_filt), .cfg_oc_thr(cfg_oc_thr),
        .frm_req(frm_req), .frm_wr(frm_wr), .frm_addr(frm_addr), .frm_wdata(frm_wdata),
        .frm_ack(frm_ack), .frm_raddr(frm_raddr), .frm_rdata(frm_rdata),
        .frm_par_err(frm_par_err), .frm_xfer_err(frm_xfer_err),
        .drv_reset_n(drv_reset_n), .drv_en(drv_en), .drv_ctrl(drv_ctrl),
        .comm_fault_en(comm_fault_en), .done(done), .error(error), .err_code(err_code)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scenario replies, indexed by frame number 0..5
    logic [3:0] r_addr [6];
    logic [7:0] r_data [6];
    logic       r_perr [6];
    logic       r_xerr [6];
    // captured frames
    logic       f_wr   [8];
    logic [3:0] f_addr [8];
    logic [7:0] f_data [8];
    int nfr;

    // reference model state
    int  cyc, dly;
    bit  pend_req, pend_done, pend_err;
    bit  want_req, exp_done, exp_err;
    logic [3:0] pend_code, exp_code;

    always @(negedge clk) begin
        if (!rst_n) begin
            nfr = 0; cyc = 0; dly = -1;
            pend_req = 0; pend_done = 0; pend_err = 0; pend_code = 0;
            exp_done = 0; exp_err = 0; exp_code = 0;
            frm_ack = 0; frm_par_err = 0; frm_xfer_err = 0;
        end else begin
            cyc++;
            want_req = (cyc == HOLD + SETTLE) || pend_req;
            if (pend_done) exp_done = 1;
            if (pend_err) begin exp_err = 1; exp_code = pend_code; end
            pend_req = 0; pend_done = 0; pend_err = 0;
            frm_ack = 0; frm_par_err = 0; frm_xfer_err = 0;

            chk(drv_reset_n == (cyc >= HOLD), "R1", "drv_reset_n", int'(drv_reset_n), int'(cyc >= HOLD));
            chk(drv_en == 1'b1, "R1", "drv_en", int'(drv_en), 1);
            chk(drv_ctrl == 4'h0, "R1", "drv_ctrl", int'(drv_ctrl), 0);
            chk(frm_req == want_req, "R10", "frm_req timing", int'(frm_req), int'(want_req));
            chk(done == exp_done, "R8", "done", int'(done), int'(exp_done));
            chk(comm_fault_en == exp_done, "R8", "comm_fault_en", int'(comm_fault_en), int'(exp_done));
            chk(error == exp_err, "R11", "error", int'(error), int'(exp_err));
            if (exp_err)
                chk(err_code == exp_code, "R9", "err_code", int'(err_code), int'(exp_code));

            if (frm_req) begin
                if (nfr < 8) begin
                    f_wr[nfr] = frm_wr; f_addr[nfr] = frm_addr; f_data[nfr] = frm_wdata;
                end
                nfr++;
                dly = LAT;
            end else if (dly > 0) begin
                dly--;
                if (dly == 0 && nfr >= 1 && nfr <= 6) begin
                    int k;
                    bit link_bad, content_bad;
                    k = nfr - 1;
                    frm_ack = 1; frm_raddr = r_addr[k]; frm_rdata = r_data[k];
                    frm_par_err = r_perr[k]; frm_xfer_err = r_xerr[k];
                    link_bad = r_perr[k] || r_xerr[k];
                    content_bad = (k == 0) ? (r_addr[k] != 4'h8 || r_data[k] != 8'hB1) :
                                  (k == 1) ? (r_addr[k] != 4'h7 || !r_data[k][0]) : 1'b0;
                    if (link_bad) begin
                        pend_err = 1; pend_code = 4'(k + 1);
                    end else if (content_bad) begin
                        pend_err = 1; pend_code = 4'(8 + k + 1);
                    end else if (k == 5) begin
                        pend_done = 1;
                    end else begin
                        pend_req = 1;
                    end
                end
            end
        end
    end

    task automatic default_replies();
        for (int i = 0; i < 6; i++) begin
            r_addr[i] = 4'h0; r_data[i] = 8'h00; r_perr[i] = 0; r_xerr[i] = 0;
        end
        r_addr[0] = 4'h8; r_data[0] = 8'hB1;
        r_addr[1] = 4'h7; r_data[1] = 8'h01;
        r_addr[2] = 4'h7; r_data[2] = 8'h81;
        r_addr[3] = 4'h1; r_addr[4] = 4'h2; r_addr[5] = 4'h3;
    endtask

    task automatic run(input string name, input int nexp);
        logic [7:0] e_data [6];
        logic [3:0] e_addr [6];
        logic       e_wr   [6];
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(drv_reset_n == 0 && frm_req == 0 && done == 0 && error == 0 && comm_fault_en == 0,
            "R1", "reset state", int'({drv_reset_n, frm_req, done, error, comm_fault_en}), 0);
        #1 rst_n = 1;
        repeat (HOLD + SETTLE + 6 * (LAT + 3) + 30) @(negedge clk);

        e_wr[0] = 0; e_addr[0] = 4'h7; e_data[0] = 8'h00;
        e_wr[1] = 0; e_addr[1] = 4'h7; e_data[1] = 8'h00;
        e_wr[2] = 1; e_addr[2] = 4'h1; e_data[2] = {2'b00, cfg_par34, cfg_par12, cfg_direct};
        e_wr[3] = 1; e_addr[3] = 4'h2; e_data[3] = {2'b00, cfg_diag_filt, 4'hF};
        e_wr[4] = 1; e_addr[4] = 4'h3; e_data[4] = {3'b000, cfg_oc_filt, cfg_oc_thr};
        e_wr[5] = 1; e_addr[5] = 4'h7; e_data[5] = 8'h80;
        chk(nfr == nexp, "R9", {name, " frame count"}, nfr, nexp);
        for (int i = 0; i < nexp && i < nfr; i++) begin
            string tag;
            tag = (i < 2) ? "R2" : (i == 2) ? "R5" : (i == 3) ? "R6" : (i == 4) ? "R7" : "R8";
            chk(f_wr[i] == e_wr[i] && f_addr[i] == e_addr[i] && f_data[i] == e_data[i], tag,
                $sformatf("%s frame %0d", name, i),
                int'({f_wr[i], f_addr[i], f_data[i]}), int'({e_wr[i], e_addr[i], e_data[i]}));
        end
    endtask

    int total_cyc = 0;
    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", total_cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R5 R6 R7 R8: clean sequence, first configuration
        default_replies();
        cfg_par12 = 1; cfg_par34 = 0; cfg_direct = 4'b0101;
        cfg_diag_filt = 2'd2; cfg_oc_filt = 3'd5; cfg_oc_thr = 2'd3;
        run("clean_a", 6);
        chk(done == 1 && err_code == 0, "R8", "clean_a end", int'({done, err_code}), 16);

        // second configuration
        default_replies();
        cfg_par12 = 0; cfg_par34 = 1; cfg_direct = 4'b1010;
        cfg_diag_filt = 2'd1; cfg_oc_filt = 3'd2; cfg_oc_thr = 2'd0;
        run("clean_b", 6);
        chk(done == 1, "R11", "clean_b done held", int'(done), 1);

        // R3: wrong identity value
        default_replies(); r_data[0] = 8'hB0;
        run("bad_id", 1);
        chk(error == 1 && err_code == 4'h9, "R3", "bad_id code", int'(err_code), 9);

        // R3: wrong identity address
        default_replies(); r_addr[0] = 4'h7;
        run("bad_id_addr", 1);
        chk(err_code == 4'h9, "R3", "bad_id_addr code", int'(err_code), 9);

        // R4: power-on latch clear
        default_replies(); r_data[1] = 8'h80;
        run("no_por", 2);
        chk(err_code == 4'hA, "R4", "no_por code", int'(err_code), 10);

        // R4: wrong address on status reply
        default_replies(); r_addr[1] = 4'h8;
        run("por_addr", 2);
        chk(err_code == 4'hA, "R4", "por_addr code", int'(err_code), 10);

        // R9: parity failure on fourth frame
        default_replies(); r_perr[3] = 1;
        run("par4", 4);
        chk(error == 1 && err_code == 4'h4 && comm_fault_en == 0, "R9", "par4 code", int'(err_code), 4);

        // R9: transfer failure on last frame
        default_replies(); r_xerr[5] = 1;
        run("xfer6", 6);
        chk(error == 1 && done == 0 && err_code == 4'h6, "R9", "xfer6 code", int'(err_code), 6);

        // R12: link fault and bad identity in the same reply
        default_replies(); r_perr[0] = 1; r_data[0] = 8'h00;
        run("collide", 1);
        chk(err_code == 4'h1, "R12", "collision code", int'(err_code), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule